// File: doc/BRIEF.md
# Register-Keyed Stride Prefetch Engine

This engine sits next to a data cache and observes every memory access. Each access carries the index of the base register that formed its address. Software loads a signed stride, counted in words, into a per-register slot. An access made through a register with a nonzero stride produces a prefetch request for the cache line that holds the access address plus that stride. Requests wait in a small queue and leave through a valid/ready handshake. The engine never stalls the access stream. When the queue is full, new requests are discarded and counted.

A stride of one selects a sequential mode. In that mode the next line is requested only when an access touches the final word of its line. Each register also holds a flag that says whether stores made through it may be cached. The engine presents that flag next to each store. Addresses are word addresses, and a line holds four words.

Top module: `stride_pf_engine`

## Requirements
- R1: After reset every stride is zero and every store-cache flag is set. The queue is empty (`pf_valid_o` = 0), `drop_cnt_o` is zero, and no access produces a request.
- R2: An access through a register whose stride is zero never produces a prefetch request.
- R3: For a stride other than 0 and 1, the stride is read as a 12-bit two's-complement word offset (range -2048 to 2047). Each access requests the line `(addr + stride)` with its two low bits cleared. Every request on `pf_line_o` has bits [1:0] equal to 0.
- R4: With stride 1, a request is made only when `acc_addr_i[1:0]` = 3, and it names the following line (`addr + 1`). Accesses at word offsets 0, 1 and 2 produce nothing.
- R5: A candidate whose target line equals the line of the triggering access is suppressed.
- R6: `st_cacheable_o` is 1 exactly when `acc_valid_i` and `acc_store_i` are both 1 and the store-cache flag of `acc_reg_i` is set. Loads always drive 0. The output is combinational in the same cycle as the access.
- R7: Requests leave in the order they were accepted. The queue holds up to 4 of them. While `pf_valid_o` is 1 and `pf_ready_i` is 0, the valid signal and `pf_line_o` hold their values.
- R8: If a new, non-duplicate request arrives while 4 requests are already queued, it is dropped. `drop_cnt_o` then rises by exactly one (saturating), and the queued requests are unchanged. The counter only changes in a cycle that follows an access.
- R9: A request whose line already sits in the queue is not queued again, and it is not counted as a drop.
- R10: A configuration write (`cfg_we_i`, `cfg_idx_i`, `cfg_stride_i`, `cfg_st_cache_i`) takes effect from the next cycle. An access in the same cycle as the write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Register slot written |
| cfg_stride_i | input | 12 | Signed stride in words |
| cfg_st_cache_i | input | 1 | Store-cacheable flag written |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_reg_i | input | 4 | Base register index of the access |
| acc_addr_i | input | 32 | Word address of the access |
| acc_store_i | input | 1 | Access is a store |
| st_cacheable_o | output | 1 | Store may be cached |
| pf_valid_o | output | 1 | Prefetch request available |
| pf_ready_i | input | 1 | Consumer takes the request |
| pf_line_o | output | 32 | Line-aligned word address to prefetch |
| drop_cnt_o | output | 16 | Saturating count of requests dropped because the queue was full |

## Verification
The checker watches four things on every cycle:
- every offered line is aligned;
- a stalled request holds its line and its valid signal;
- the cacheable flag is raised only for stores;
- the drop counter moves by at most one, and only after an access.

The bench scenarios cover what depends on programmed state or on exact values. These include the computed target for positive, negative and extreme strides, end-of-line sequential triggering, same-line suppression, duplicate merging, drop on a full queue, FIFO order, and the write-versus-access race in a single cycle.

// File: rtl/pf_pkg.sv
package pf_pkg;

   typedef enum logic [1:0] {
      PF_MODE_OFF    = 2'd0,
      PF_MODE_SEQ    = 2'd1,
      PF_MODE_STRIDE = 2'd2
   } pf_mode_e;

   function automatic pf_mode_e pf_decode_mode(input logic is_zero, input logic is_one);
      if (is_zero)
         return PF_MODE_OFF;
      else if (is_one)
         return PF_MODE_SEQ;
      else
         return PF_MODE_STRIDE;
   endfunction

endpackage

// File: rtl/pf_stride_table.sv
module pf_stride_table #(
   parameter int NUM_REGS  = 16,
   parameter int STRIDE_W  = 12,
   localparam int REG_IDX_W = $clog2(NUM_REGS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_en_i,
   input  logic [REG_IDX_W-1:0] wr_idx_i,
   input  logic [STRIDE_W-1:0]  wr_stride_i,
   input  logic                 wr_st_cache_i,
   input  logic [REG_IDX_W-1:0] rd_idx_i,
   output logic [STRIDE_W-1:0]  rd_stride_o,
   output logic                 rd_st_cache_o
);

   logic [STRIDE_W-1:0] stride_q [NUM_REGS];
   logic [NUM_REGS-1:0] st_cache_q;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
      logic hit;
      assign hit = wr_en_i && (wr_idx_i == REG_IDX_W'(g));

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            stride_q[g]   <= '0;
            st_cache_q[g] <= 1'b1;
         end else if (hit) begin
            stride_q[g]   <= wr_stride_i;
            st_cache_q[g] <= wr_st_cache_i;
         end
      end
   end

   assign rd_stride_o   = stride_q[rd_idx_i];
   assign rd_st_cache_o = st_cache_q[rd_idx_i];

endmodule

// File: rtl/pf_target_calc.sv
module pf_target_calc
   import pf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int STRIDE_W   = 12,
   parameter int LINE_WORDS = 4,
   localparam int OFS_W     = $clog2(LINE_WORDS)
) (
   input  logic                acc_valid_i,
   input  logic [ADDR_W-1:0]   acc_addr_i,
   input  logic [STRIDE_W-1:0] stride_i,
   output logic                cand_valid_o,
   output logic [ADDR_W-1:0]   cand_line_o
);

   pf_mode_e            mode;
   logic [ADDR_W-1:0]   stride_ext;
   logic [ADDR_W-1:0]   sum;
   logic                at_last_word;
   logic                crosses;
   logic                mode_fire;

   always_comb begin
      mode         = pf_decode_mode(stride_i == '0, stride_i == STRIDE_W'(1));
      stride_ext   = {{(ADDR_W-STRIDE_W){stride_i[STRIDE_W-1]}}, stride_i};
      sum          = acc_addr_i + stride_ext;
      at_last_word = &acc_addr_i[OFS_W-1:0];
      crosses      = sum[ADDR_W-1:OFS_W] != acc_addr_i[ADDR_W-1:OFS_W];
      unique case (mode)
         PF_MODE_OFF:    mode_fire = 1'b0;
         PF_MODE_SEQ:    mode_fire = at_last_word;
         PF_MODE_STRIDE: mode_fire = 1'b1;
         default:        mode_fire = 1'b0;
      endcase
      cand_valid_o = acc_valid_i && mode_fire && crosses;
      cand_line_o  = {sum[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
   end

endmodule

// File: rtl/pf_req_queue.sv
module pf_req_queue #(
   parameter int ADDR_W   = 32,
   parameter int DEPTH    = 4,
   parameter int CNT_W    = 16,
   parameter bit DEDUP_EN = 1'b1,
   parameter bit DROP_SAT = 1'b1,
   localparam int PTR_W   = $clog2(DEPTH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_valid_i,
   input  logic [ADDR_W-1:0] push_line_i,
   input  logic              pop_ready_i,
   output logic              head_valid_o,
   output logic [ADDR_W-1:0] head_line_o,
   output logic [CNT_W-1:0]  drop_cnt_o
);

   logic [ADDR_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [PTR_W:0]    count;
   logic [DEPTH-1:0]  match;
   logic              dup, full, do_push, do_drop, do_pop;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      logic [PTR_W-1:0] rel;
      assign rel      = PTR_W'(i) - rd_ptr;
      assign match[i] = ({1'b0, rel} < count) && (mem[i] == push_line_i);
   end

   if (DEDUP_EN) begin : g_dedup
      assign dup = |match;
   end else begin : g_nodedup
      assign dup = 1'b0;
   end

   assign full    = count == (PTR_W+1)'(DEPTH);
   assign do_push = push_valid_i && !dup && !full;
   assign do_drop = push_valid_i && !dup && full;
   assign head_valid_o = count != '0;
   assign head_line_o  = mem[rd_ptr];
   assign do_pop  = head_valid_o && pop_ready_i;

   always_ff @(posedge clk_i) begin
      if (do_push)
         mem[wr_ptr] <= push_line_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
      end
   end

   if (DROP_SAT) begin : g_sat
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            drop_cnt_o <= '0;
         else if (do_drop && drop_cnt_o != '1)
            drop_cnt_o <= drop_cnt_o + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            drop_cnt_o <= '0;
         else if (do_drop)
            drop_cnt_o <= drop_cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/stride_pf_engine.sv
module stride_pf_engine #(
   parameter int NUM_REGS   = 16,
   parameter int STRIDE_W   = 12,
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int Q_DEPTH    = 4,
   parameter int CNT_W      = 16,
   localparam int REG_IDX_W = $clog2(NUM_REGS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cfg_we_i,
   input  logic [REG_IDX_W-1:0] cfg_idx_i,
   input  logic [STRIDE_W-1:0]  cfg_stride_i,
   input  logic                 cfg_st_cache_i,
   input  logic                 acc_valid_i,
   input  logic [REG_IDX_W-1:0] acc_reg_i,
   input  logic [ADDR_W-1:0]    acc_addr_i,
   input  logic                 acc_store_i,
   output logic                 st_cacheable_o,
   output logic                 pf_valid_o,
   input  logic                 pf_ready_i,
   output logic [ADDR_W-1:0]    pf_line_o,
   output logic [CNT_W-1:0]     drop_cnt_o
);

   if ((NUM_REGS < 2) || ((NUM_REGS & (NUM_REGS-1)) != 0)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two >= 2");
   end
   if ((LINE_WORDS < 2) || ((LINE_WORDS & (LINE_WORDS-1)) != 0)) begin : g_bad_line
      $error("LINE_WORDS must be a power of two >= 2");
   end
   if ((Q_DEPTH < 2) || ((Q_DEPTH & (Q_DEPTH-1)) != 0)) begin : g_bad_depth
      $error("Q_DEPTH must be a power of two >= 2");
   end
   if (STRIDE_W >= ADDR_W) begin : g_bad_stride
      $error("STRIDE_W must be narrower than ADDR_W");
   end

   logic [STRIDE_W-1:0] sel_stride;
   logic                sel_st_cache;
   logic                cand_valid;
   logic [ADDR_W-1:0]   cand_line;

   pf_stride_table #(
      .NUM_REGS (NUM_REGS),
      .STRIDE_W (STRIDE_W)
   ) table_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_en_i       (cfg_we_i),
      .wr_idx_i      (cfg_idx_i),
      .wr_stride_i   (cfg_stride_i),
      .wr_st_cache_i (cfg_st_cache_i),
      .rd_idx_i      (acc_reg_i),
      .rd_stride_o   (sel_stride),
      .rd_st_cache_o (sel_st_cache)
   );

   pf_target_calc #(
      .ADDR_W     (ADDR_W),
      .STRIDE_W   (STRIDE_W),
      .LINE_WORDS (LINE_WORDS)
   ) calc_i (
      .acc_valid_i  (acc_valid_i),
      .acc_addr_i   (acc_addr_i),
      .stride_i     (sel_stride),
      .cand_valid_o (cand_valid),
      .cand_line_o  (cand_line)
   );

   pf_req_queue #(
      .ADDR_W   (ADDR_W),
      .DEPTH    (Q_DEPTH),
      .CNT_W    (CNT_W),
      .DEDUP_EN (1'b1),
      .DROP_SAT (1'b1)
   ) queue_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_valid_i (cand_valid),
      .push_line_i  (cand_line),
      .pop_ready_i  (pf_ready_i),
      .head_valid_o (pf_valid_o),
      .head_line_o  (pf_line_o),
      .drop_cnt_o   (drop_cnt_o)
   );

   assign st_cacheable_o = acc_valid_i && acc_store_i && sel_st_cache;

endmodule

// File: rtl/pf_engine_chk.sv
module pf_engine_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int CNT_W      = 16,
   localparam int OFS_W     = $clog2(LINE_WORDS)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              acc_valid_i,
   input logic              acc_store_i,
   input logic              st_cacheable_o,
   input logic              pf_valid_o,
   input logic              pf_ready_i,
   input logic [ADDR_W-1:0] pf_line_o,
   input logic [CNT_W-1:0]  drop_cnt_o
);

   // R3
   pf_line_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pf_valid_o |-> (pf_line_o[OFS_W-1:0] == '0));

   // R7
   pf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_line_o)));

   // R6
   st_cacheable_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_cacheable_o |-> (acc_valid_i && acc_store_i));

   // R8
   drop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((drop_cnt_o == $past(drop_cnt_o)) ||
                (drop_cnt_o == $past(drop_cnt_o) + 1'b1)));

   // R8
   drop_needs_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc_valid_i |=> $stable(drop_cnt_o));

endmodule

bind stride_pf_engine pf_engine_chk #(
   .ADDR_W     (ADDR_W),
   .LINE_WORDS (LINE_WORDS),
   .CNT_W      (CNT_W)
) chk_i (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .acc_valid_i    (acc_valid_i),
   .acc_store_i    (acc_store_i),
   .st_cacheable_o (st_cacheable_o),
   .pf_valid_o     (pf_valid_o),
   .pf_ready_i     (pf_ready_i),
   .pf_line_o      (pf_line_o),
   .drop_cnt_o     (drop_cnt_o)
);

// File: tb/stride_pf_engine_tb_top.sv
`timescale 1ns/1ps
module stride_pf_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [11:0] cfg_stride = '0;
   logic        cfg_sc = 1'b0;
   logic        acc_valid = 1'b0;
   logic [3:0]  acc_reg = '0;
   logic [31:0] acc_addr = '0;
   logic        acc_store = 1'b0;
   logic        st_cacheable;
   logic        pf_valid;
   logic        pf_ready = 1'b0;
   logic [31:0] pf_line;
   logic [15:0] drop_cnt;

   int checks = 0;
   int errors = 0;
   int exp_drop = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   stride_pf_engine dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .cfg_we_i       (cfg_we),
      .cfg_idx_i      (cfg_idx),
      .cfg_stride_i   (cfg_stride),
      .cfg_st_cache_i (cfg_sc),
      .acc_valid_i    (acc_valid),
      .acc_reg_i      (acc_reg),
      .acc_addr_i     (acc_addr),
      .acc_store_i    (acc_store),
      .st_cacheable_o (st_cacheable),
      .pf_valid_o     (pf_valid),
      .pf_ready_i     (pf_ready),
      .pf_line_o      (pf_line),
      .drop_cnt_o     (drop_cnt)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg(input int idx, input int stride, input bit sc);
      cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_stride = 12'(stride); cfg_sc = sc;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic acc(input int r, input logic [31:0] a, input bit st);
      acc_valid = 1'b1; acc_reg = 4'(r); acc_addr = a; acc_store = st;
      @(negedge clk);
      acc_valid = 1'b0; acc_store = 1'b0;
   endtask

   task automatic pop_expect(input logic [31:0] line, input string req);
      chk(pf_valid == 1'b1, req, "pf_valid", pf_valid, 1);
      chk(pf_line == line, req, "pf_line", pf_line, line);
      pf_ready = 1'b1;
      @(negedge clk);
      pf_ready = 1'b0;
   endtask

   task automatic expect_empty(input string req);
      chk(pf_valid == 1'b0, req, "queue empty", pf_valid, 0);
   endtask

   task automatic st_probe(input int r, input bit st, input bit exp);
      acc_valid = 1'b1; acc_reg = 4'(r); acc_addr = 32'h80; acc_store = st;
      #1;
      chk(st_cacheable == exp, "R6", "st_cacheable", st_cacheable, exp);
      @(negedge clk);
      acc_valid = 1'b0; acc_store = 1'b0;
   endtask

   task automatic t_reset();
      expect_empty("R1");
      chk(drop_cnt == 0, "R1", "drop_cnt", drop_cnt, 0);
      acc_valid = 1'b1; acc_reg = 4'd5; acc_addr = 32'h13; acc_store = 1'b1;
      #1;
      chk(st_cacheable == 1'b1, "R1", "reset store-cache flag", st_cacheable, 1);
      @(negedge clk);
      acc_valid = 1'b0; acc_store = 1'b0;
      expect_empty("R1");
   endtask

   task automatic t_zero();
      cfg(0, 5, 1);
      cfg(0, 0, 1);
      acc(0, 32'h23, 0);
      acc(0, 32'h1003, 0);
      expect_empty("R2");
   endtask

   task automatic t_stride();
      cfg(1, 8, 1);
      acc(1, 32'h100, 0);
      pop_expect(32'h108, "R3");
      cfg(2, -6, 1);
      acc(2, 32'h203, 0);
      pop_expect(32'h1FC, "R3");
      cfg(8, -2048, 1);
      acc(8, 32'h1000, 0);
      pop_expect(32'h800, "R3");
      cfg(9, 2047, 1);
      acc(9, 32'h0, 1);
      pop_expect(32'h7FC, "R3");
      expect_empty("R3");
   endtask

   task automatic t_seq();
      cfg(3, 1, 1);
      acc(3, 32'h40, 0);
      acc(3, 32'h41, 0);
      acc(3, 32'h42, 0);
      expect_empty("R4");
      acc(3, 32'h43, 0);
      pop_expect(32'h44, "R4");
      expect_empty("R4");
   endtask

   task automatic t_same();
      cfg(4, 2, 1);
      acc(4, 32'h50, 0);
      expect_empty("R5");
      acc(4, 32'h52, 0);
      pop_expect(32'h54, "R5");
      cfg(4, -1, 1);
      acc(4, 32'h61, 0);
      expect_empty("R5");
      acc(4, 32'h60, 0);
      pop_expect(32'h5C, "R5");
   endtask

   task automatic t_stcache();
      cfg(6, 0, 0);
      st_probe(6, 1, 0);
      st_probe(6, 0, 0);
      st_probe(5, 0, 0);
      st_probe(5, 1, 1);
      cfg(6, 0, 1);
      st_probe(6, 1, 1);
   endtask

   task automatic t_order();
      acc(1, 32'h200, 0);
      acc(1, 32'h300, 0);
      acc(1, 32'h400, 0);
      chk(pf_line == 32'h208, "R7", "head before stall", pf_line, 32'h208);
      @(negedge clk);
      @(negedge clk);
      chk(pf_valid == 1'b1 && pf_line == 32'h208, "R7", "head held", pf_line, 32'h208);
      pop_expect(32'h208, "R7");
      pop_expect(32'h308, "R7");
      pop_expect(32'h408, "R7");
      expect_empty("R7");
   endtask

   task automatic t_dup();
      acc(1, 32'h500, 0);
      acc(1, 32'h501, 0);
      acc(1, 32'h502, 0);
      chk(drop_cnt == 16'(exp_drop), "R9", "drop_cnt after dup", drop_cnt, exp_drop);
      pop_expect(32'h508, "R9");
      expect_empty("R9");
   endtask

   task automatic t_full();
      acc(1, 32'h600, 0);
      acc(1, 32'h700, 0);
      acc(1, 32'h800, 0);
      acc(1, 32'h900, 0);
      chk(drop_cnt == 16'(exp_drop), "R8", "drop_cnt before overflow", drop_cnt, exp_drop);
      acc(1, 32'hA00, 0);
      exp_drop++;
      chk(drop_cnt == 16'(exp_drop), "R8", "drop_cnt one drop", drop_cnt, exp_drop);
      acc(1, 32'hB00, 0);
      exp_drop++;
      chk(drop_cnt == 16'(exp_drop), "R8", "drop_cnt two drops", drop_cnt, exp_drop);
      acc(1, 32'h601, 0);
      chk(drop_cnt == 16'(exp_drop), "R9", "dup while full not dropped", drop_cnt, exp_drop);
      pop_expect(32'h608, "R8");
      pop_expect(32'h708, "R8");
      pop_expect(32'h808, "R8");
      pop_expect(32'h908, "R8");
      expect_empty("R8");
   endtask

   task automatic t_cfg_race();
      cfg_we = 1'b1; cfg_idx = 4'd10; cfg_stride = 12'd8; cfg_sc = 1'b1;
      acc_valid = 1'b1; acc_reg = 4'd10; acc_addr = 32'h700; acc_store = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0; acc_valid = 1'b0;
      expect_empty("R10");
      acc(10, 32'h700, 0);
      pop_expect(32'h708, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero();
      t_stride();
      t_seq();
      t_same();
      t_stcache();
      t_order();
      t_dup();
      t_full();
      t_cfg_race();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule